// File: doc/BRIEF.md
# Modem Handshake Delay Timer

This block turns a raw request-to-send level and a fast carrier-detect flag into the delayed handshake outputs of a low-speed frequency-shift modem. Clear-to-send (active low) is granted only after a programmable delay has passed since the request. A qualified carrier-detect flag follows the fast flag, with a long delay on the way up and a short one on the way down. Every delay is counted in ticks of a slow timebase. The timebase comes from the master clock through a power-of-two divider, and its square wave is brought out on a pin so that external timers can use it.

A two-bit group select picks one of three built-in delay groups. The request path and the carrier path always switch groups together. The fourth select code turns the internal timers off, and each output then tracks an externally delayed input. With the default divider of 4096 and a 3.579545 MHz master clock, one tick lasts about 1.144 ms, so each table entry is simply the wanted delay expressed in ticks.

Top module: `hs_delay_timer`

## Requirements
- R1: While the synchronous active-low reset is held, `cts_n` is 1, `cd_qual` is 0 and `clk_div` is 0. This holds even when reset is applied in the middle of a delay or while clear-to-send is granted.
- R2: `clk_div` is a square wave with a period of 2^DIV_LOG2 master clocks. It is low for the first half period after reset is released. Each falling edge of `clk_div` is one timebase tick.
- R3: With `dly_sel` set to 0, 1 or 2 and `rts_n` driven low, `cts_n` goes low on exactly the Nth falling edge of `clk_div` after the change. N is 350, 26 or 306 for select values 0, 1 and 2.
- R4: When `rts_n` returns high outside bypass, `cts_n` is 1 after the next clock edge.
- R5: A low pulse on `rts_n` that ends before its delay expires resets the count. `cts_n` stays high, and a new request is timed for a full N ticks from the moment it starts.
- R6: With `dly_sel` 0, 1 or 2 and `cd_fast` raised, `cd_qual` rises on exactly the Nth tick after the change. N is 271, 10 or 140 for select values 0, 1 and 2.
- R7: When `cd_fast` drops while `cd_qual` is 1, `cd_qual` falls on exactly the Nth tick. N is 39, 39 or 22 for select values 0, 1 and 2. A drop shorter than that never reaches `cd_qual`.
- R8: With `dly_sel` equal to 3 (both bits high), `cts_n` follows `ext_rts_n` and `cd_qual` follows `ext_cd`, each one clock later. `rts_n` and `cd_fast` are ignored in this mode. After leaving this mode, each path starts from the level it last took from its external input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rts_n | input | 1 | Raw request to send, active low |
| cd_fast | input | 1 | Undelayed carrier-detect flag, active high |
| dly_sel | input | 2 | Delay group select; 3 selects external delays |
| ext_rts_n | input | 1 | Externally delayed request, used when dly_sel is 3 |
| ext_cd | input | 1 | Externally delayed carrier detect, used when dly_sel is 3 |
| cts_n | output | 1 | Clear to send, active low |
| cd_qual | output | 1 | Qualified carrier detect, active high |
| clk_div | output | 1 | Divided timebase clock |

## Verification
The assertions assume that all inputs are already synchronous to `clk`. They also assume that `dly_sel` does not change while a delay is running, because the bound on the running count compares it against the group that is selected at that moment. The stimulus drives every input on the falling clock edge. It changes `dly_sel` only while both paths rest at their input levels, or while the block is in bypass. Tick-exact checks are taken just after a falling edge of `clk_div`, since that is the edge on which the counters advance.

// File: rtl/hs_delay_pkg.sv
// Package: shared types and constants for the handshake delay timer.
// Assumes tick counts fit in TICK_W bits.
package hs_delay_pkg;

    localparam int TICK_W = 12;

    typedef logic [TICK_W-1:0] tick_cnt_t;
    typedef logic [1:0]        dly_code_t;

    // Select code that hands both paths over to the external delayed inputs.
    localparam dly_code_t EXT_CODE = 2'b11;

    typedef struct packed {
        tick_cnt_t rs_on;
        tick_cnt_t rs_off;
        tick_cnt_t cd_on;
        tick_cnt_t cd_off;
    } dly_group_t;

endpackage

// File: rtl/hs_timebase.sv
// Module: power-of-two timebase divider.
// Produces a one-cycle tick when the counter wraps, and a square-wave clock
// that is the counter MSB. The tick coincides with the MSB falling edge.
// Assumes DIV_LOG2 >= 1.
module hs_timebase #(
    parameter int DIV_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic clk_div
);
    localparam int CW = DIV_LOG2;

    logic [CW-1:0] div_cnt;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    assign tick    = &div_cnt;
    assign clk_div = div_cnt[CW-1];

    AST_TICK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> $fell(clk_div)); // R2
    AST_NO_FALL_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && rst_n) |=> !$fell(clk_div)); // R2

endmodule

// File: rtl/hs_group_sel.sv
// Module: delay group table lookup.
// Maps the two-bit select code to the four tick counts of one group.
// The external code yields zeros, which the caller ignores in bypass.
// Assumes every table entry fits in TICK_W bits.
module hs_group_sel
    import hs_delay_pkg::*;
#(
    parameter int unsigned RS_ON_TICKS  [3] = '{350, 26, 306},
    parameter int unsigned RS_OFF_TICKS [3] = '{0, 0, 0},
    parameter int unsigned CD_ON_TICKS  [3] = '{271, 10, 140},
    parameter int unsigned CD_OFF_TICKS [3] = '{39, 39, 22}
) (
    input  dly_code_t  code,
    output dly_group_t grp
);
    dly_group_t table_q [4];

    // Build the internal groups; the last slot is the bypass slot.
    for (genvar g = 0; g < 3; g++) begin : g_tab
        assign table_q[g].rs_on  = tick_cnt_t'(RS_ON_TICKS[g]);
        assign table_q[g].rs_off = tick_cnt_t'(RS_OFF_TICKS[g]);
        assign table_q[g].cd_on  = tick_cnt_t'(CD_ON_TICKS[g]);
        assign table_q[g].cd_off = tick_cnt_t'(CD_OFF_TICKS[g]);
    end
    assign table_q[3] = '0;

    // Select the active group.
    always_comb grp = table_q[code];

endmodule

// File: rtl/hs_level_qualifier.sv
// Module: asymmetric level qualifier.
// The output follows the request once it has differed from the output for
// the on (rising) or off (falling) tick count. A zero count means follow on
// the next clock. Any cycle in which request and output agree clears the
// count, so short excursions never pass. In bypass the output copies ext_val.
// Assumes inputs are synchronous and that the counts change only while idle.
module hs_level_qualifier
    import hs_delay_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      bypass,
    input  logic      ext_val,
    input  logic      req,
    input  tick_cnt_t on_ticks,
    input  tick_cnt_t off_ticks,
    output logic      q
);
    tick_cnt_t cnt;
    tick_cnt_t target;
    logic      busy;

    // Target depends on which direction the output would move.
    always_comb begin
        target = q ? off_ticks : on_ticks;
        busy   = !bypass && (req != q);
    end

    // Count ticks while request differs from output; switch on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (bypass) begin
            q   <= ext_val;
            cnt <= '0;
        end else if (req == q) begin
            cnt <= '0;
        end else if (target == '0) begin
            q   <= req;
            cnt <= '0;
        end else if (tick) begin
            if (cnt + 1'b1 >= target) begin
                q   <= req;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && target != '0) |-> (cnt < target)); // R3
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bypass && target != '0) |=> $stable(q)); // R6
    AST_AGREE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && req == q) |=> (cnt == '0)); // R5

endmodule

// File: rtl/hs_delay_timer.sv
// Module: handshake delay timer top.
// Derives the timebase, looks up the selected delay group and qualifies
// the request path (active-low in and out) and the carrier path.
// Select code 3 bypasses both qualifiers in favour of external inputs.
// Assumes all inputs are synchronous to clk.
module hs_delay_timer
    import hs_delay_pkg::*;
#(
    parameter int DIV_LOG2 = 12,
    parameter int unsigned RS_ON_TICKS  [3] = '{350, 26, 306},
    parameter int unsigned RS_OFF_TICKS [3] = '{0, 0, 0},
    parameter int unsigned CD_ON_TICKS  [3] = '{271, 10, 140},
    parameter int unsigned CD_OFF_TICKS [3] = '{39, 39, 22}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rts_n,
    input  logic       cd_fast,
    input  logic [1:0] dly_sel,
    input  logic       ext_rts_n,
    input  logic       ext_cd,
    output logic       cts_n,
    output logic       cd_qual,
    output logic       clk_div
);
    logic       tick;
    logic       bypass;
    logic       rs_q;
    dly_group_t grp;

    hs_timebase #(.DIV_LOG2(DIV_LOG2)) tb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clk_div (clk_div)
    );

    hs_group_sel #(
        .RS_ON_TICKS  (RS_ON_TICKS),
        .RS_OFF_TICKS (RS_OFF_TICKS),
        .CD_ON_TICKS  (CD_ON_TICKS),
        .CD_OFF_TICKS (CD_OFF_TICKS)
    ) sel_i (
        .code (dly_sel),
        .grp  (grp)
    );

    // Bypass decode for the external-timer code.
    always_comb bypass = (dly_sel == EXT_CODE);

    hs_level_qualifier rs_qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bypass    (bypass),
        .ext_val   (~ext_rts_n),
        .req       (~rts_n),
        .on_ticks  (grp.rs_on),
        .off_ticks (grp.rs_off),
        .q         (rs_q)
    );

    hs_level_qualifier cd_qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bypass    (bypass),
        .ext_val   (ext_cd),
        .req       (cd_fast),
        .on_ticks  (grp.cd_on),
        .off_ticks (grp.cd_off),
        .q         (cd_qual)
    );

    // Clear to send is the active-low form of the qualified request.
    assign cts_n = ~rs_q;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (cts_n && !cd_qual && !clk_div)); // R1
    AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_n && dly_sel != EXT_CODE) |=> cts_n); // R4
    AST_BYPASS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_sel == EXT_CODE) |=> (cts_n == $past(ext_rts_n))); // R8
    AST_BYPASS_CD: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_sel == EXT_CODE) |=> (cd_qual == $past(ext_cd))); // R8

endmodule

// File: tb/hs_delay_timer_tb.sv
module hs_delay_timer_tb_top;

    localparam int DIVL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rts_n = 1'b1;
    logic       cd_fast = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic       ext_rts_n = 1'b1;
    logic       ext_cd = 1'b0;
    logic       cts_n;
    logic       cd_qual;
    logic       clk_div;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hs_delay_timer #(.DIV_LOG2(DIVL)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rts_n     (rts_n),
        .cd_fast   (cd_fast),
        .dly_sel   (dly_sel),
        .ext_rts_n (ext_rts_n),
        .ext_cd    (ext_cd),
        .cts_n     (cts_n),
        .cd_qual   (cd_qual),
        .clk_div   (clk_div)
    );

    // Vector: select code, path kind (0 request on, 1 carrier on, 2 carrier off), ticks.
    typedef struct packed {
        logic [1:0]  code;
        logic [1:0]  kind;
        logic [11:0] ticks;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd0, 2'd0, 12'd350}, '{2'd0, 2'd1, 12'd271}, '{2'd0, 2'd2, 12'd39},
        '{2'd1, 2'd0, 12'd26},  '{2'd1, 2'd1, 12'd10},  '{2'd1, 2'd2, 12'd39},
        '{2'd2, 2'd0, 12'd306}, '{2'd2, 2'd1, 12'd140}, '{2'd2, 2'd2, 12'd22}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(negedge clk_div);
        #1;
    endtask

    initial begin : watchdog
        #(150000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic ok;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 cts_n in reset", cts_n, 1'b1);
        check("R1 cd_qual in reset", cd_qual, 1'b0);
        check("R1 clk_div in reset", clk_div, 1'b0);

        // R2: divider waveform after reset release
        @(negedge clk);
        rst_n = 1'b1;
        ok = 1'b1;
        for (int k = 1; k <= 24; k++) begin
            @(posedge clk);
            #1;
            if (clk_div !== 1'((k >> (DIVL - 1)) & 1)) ok = 1'b0;
        end
        check("R2 clk_div square wave", ok, 1'b1);

        // Table walk: R3, R4, R6, R7 per delay group
        for (int v = 0; v < 9; v++) begin
            @(negedge clk);
            dly_sel = VECS[v].code;
            case (VECS[v].kind)
                2'd0: begin
                    @(negedge clk);
                    rts_n = 1'b0;
                    wait_ticks(int'(VECS[v].ticks) - 1);
                    check("R3 cts_n before delay", cts_n, 1'b1);
                    wait_ticks(1);
                    check("R3 cts_n at delay", cts_n, 1'b0);
                    @(negedge clk);
                    rts_n = 1'b1;
                    @(posedge clk);
                    #1;
                    check("R4 cts_n release", cts_n, 1'b1);
                end
                2'd1: begin
                    @(negedge clk);
                    cd_fast = 1'b1;
                    wait_ticks(int'(VECS[v].ticks) - 1);
                    check("R6 cd_qual before delay", cd_qual, 1'b0);
                    wait_ticks(1);
                    check("R6 cd_qual at delay", cd_qual, 1'b1);
                end
                default: begin
                    @(negedge clk);
                    cd_fast = 1'b0;
                    wait_ticks(int'(VECS[v].ticks) - 1);
                    check("R7 cd_qual before off delay", cd_qual, 1'b1);
                    wait_ticks(1);
                    check("R7 cd_qual at off delay", cd_qual, 1'b0);
                end
            endcase
        end

        // R5: request glitch restarts the count (group 1, 26 ticks)
        @(negedge clk);
        dly_sel = 2'd1;
        @(negedge clk);
        rts_n = 1'b0;
        wait_ticks(20);
        @(negedge clk);
        rts_n = 1'b1;
        @(negedge clk);
        rts_n = 1'b0;
        wait_ticks(25);
        check("R5 cts_n after restart", cts_n, 1'b1);
        wait_ticks(1);
        check("R5 cts_n full delay", cts_n, 1'b0);
        @(negedge clk);
        rts_n = 1'b1;

        // R7: short carrier drop is filtered (group 1, off 39 ticks)
        @(negedge clk);
        cd_fast = 1'b1;
        wait_ticks(10);
        check("R7 setup cd_qual", cd_qual, 1'b1);
        @(negedge clk);
        cd_fast = 1'b0;
        wait_ticks(30);
        @(negedge clk);
        cd_fast = 1'b1;
        wait_ticks(45);
        check("R7 short drop filtered", cd_qual, 1'b1);

        // R8: bypass follows external inputs, raw inputs ignored
        @(negedge clk);
        dly_sel = 2'd3;
        rts_n = 1'b1;
        cd_fast = 1'b1;
        ext_rts_n = 1'b0;
        ext_cd = 1'b0;
        @(posedge clk);
        #1;
        check("R8 cts_n follows ext", cts_n, 1'b0);
        check("R8 cd_qual follows ext", cd_qual, 1'b0);
        @(negedge clk);
        ext_rts_n = 1'b1;
        ext_cd = 1'b1;
        rts_n = 1'b0;
        cd_fast = 1'b0;
        @(posedge clk);
        #1;
        check("R8 cts_n ignores rts_n", cts_n, 1'b1);
        check("R8 cd_qual ignores cd_fast", cd_qual, 1'b1);
        // Leave bypass: request path resumes from external level (inactive)
        @(negedge clk);
        dly_sel = 2'd1;
        wait_ticks(25);
        check("R8 exit cts_n still high", cts_n, 1'b1);
        wait_ticks(1);
        check("R8 exit cts_n after delay", cts_n, 1'b0);

        // R1: reset in mid-operation with clear-to-send granted
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run cts_n", cts_n, 1'b1);
        check("R1 mid-run cd_qual", cd_qual, 1'b0);
        check("R1 mid-run clk_div", clk_div, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule